// File: doc/BRIEF.md
# Branch Condition and Next-PC Unit

This unit resolves one control-transfer instruction per clock. It takes the 8-bit opcode, a signed 16-bit displacement, a 32-bit immediate, the values of the destination and source registers, and the address of the current instruction. One cycle later it returns four things: the address of the next instruction, a flag that says whether the branch was taken, a strobe for a function call with the function number, and a strobe that halts the program. A separate flag marks encodings that are not legal.

The unit compares in one of two widths, and the instruction class selects the width. The wide class compares full 64-bit values. The narrow class compares only the low 32 bits. Each compare has a signed and an unsigned variant. There are also equality, inequality and bit-test conditions. Addresses count whole 64-bit instruction slots, so an instruction that falls through always moves the program counter forward by one.

The unit does not run the called function and does not keep a return stack. It only reports the call. A fetch stage upstream of the unit is expected to drive `in_valid` for each jump-class instruction. The stages around the unit use `next_pc` and the strobes.

Top module: `jump_resolver`

## Requirements
- R1: While reset is held, and until the two-flop reset release has completed, `out_valid`, `taken`, `call_stb`, `halt_stb` and `illegal` are 0 and `next_pc` is 0.
- R2: An instruction presented with `in_valid` high at a clock edge produces its result at the outputs after that edge, with `out_valid` high. In a cycle that follows an edge with `in_valid` low, `out_valid`, `taken`, `call_stb`, `halt_stb` and `illegal` are all 0, and `next_pc` keeps its previous value.
- R3: The opcode fields are as follows. Bits [2:0] hold the class: 5 is the 64-bit class and 6 is the 32-bit class. Bit 3 set selects the source register as the comparand. Bit 3 clear selects the immediate, which is sign-extended to 64 bits.
- R4: In the 64-bit class, bits [7:4] select the condition on the full operands. The codes are: 1 equal, 5 not equal, 2 unsigned greater, 3 unsigned greater-or-equal, 10 unsigned less, 11 unsigned less-or-equal, 6 signed greater, 7 signed greater-or-equal, 12 signed less, 13 signed less-or-equal, and 4 for a nonzero bitwise AND.
- R5: In the 32-bit class, the same condition codes look only at bits [31:0] of each operand. The sign for the signed compares is taken from bit 31.
- R6: When a branch is taken, `next_pc` = `pc` + 1 + the sign-extended offset, wrapping modulo 2^32. In every other case `next_pc` = `pc` + 1.
- R7: Code 0 in the 64-bit class (opcode 0x05) is always taken.
- R8: Code 8 with an immediate source (opcodes 0x85 and 0x86) raises `call_stb` with `call_fn` equal to the immediate. In that case `taken` is 0 and `next_pc` = `pc` + 1.
- R9: Code 9 in the 64-bit class (opcodes 0x95 and 0x9d) raises `halt_stb`. In that case `taken` is 0 and `next_pc` = `pc` + 1.
- R10: The following raise `illegal`, with `taken`, `call_stb` and `halt_stb` all 0 and `next_pc` = `pc` + 1: any class other than 5 or 6; code 8 with bit 3 set (for example 0x8d); codes 0 and 9 in the 32-bit class; and codes 14 and 15.
- R11: In any cycle, at most one of `taken`, `call_stb`, `halt_stb` and `illegal` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | Code, source-select bit and class |
| offset | input | 16 | Signed branch displacement in slots |
| imm | input | 32 | Immediate comparand or function number |
| dst_val | input | 64 | Destination register value |
| src_val | input | 64 | Source register value |
| pc | input | 32 | Slot address of this instruction |
| out_valid | output | 1 | Result present |
| next_pc | output | 32 | Address of the next instruction |
| taken | output | 1 | Branch taken |
| call_stb | output | 1 | Function call requested |
| call_fn | output | 32 | Function number of the call |
| halt_stb | output | 1 | Program exit |
| illegal | output | 1 | Encoding rejected |

## Verification
Each compare is driven with operand pairs that are equal, ordered the same way under signed and unsigned rules, and ordered opposite ways (all-ones against one). These pairs separate every signed code from its unsigned twin. In the 32-bit class the operands differ only above bit 31, or carry bit 31 set, which shows that the upper half is ignored and that the sign comes from bit 31. Immediate comparands of -1 against an all-ones register show the sign extension. Offsets that are negative from address 0, or that cross the top of the address space, exercise the wrap. Runs with idle cycles mixed in and back-to-back instructions check the hold and strobe behaviour.

// File: rtl/jr_pkg.sv
package jr_pkg;
  localparam logic [2:0] CLS_WIDE   = 3'd5;
  localparam logic [2:0] CLS_NARROW = 3'd6;

  typedef enum logic [3:0] {
    C_ALWAYS = 4'h0, C_EQ  = 4'h1, C_UGT = 4'h2, C_UGE = 4'h3,
    C_SET    = 4'h4, C_NE  = 4'h5, C_SGT = 4'h6, C_SGE = 4'h7,
    C_CALL   = 4'h8, C_EXIT = 4'h9, C_ULT = 4'ha, C_ULE = 4'hb,
    C_SLT    = 4'hc, C_SLE = 4'hd, C_RSV0 = 4'he, C_RSV1 = 4'hf
  } cond_e;

  typedef enum logic [2:0] {
    K_COND, K_ALWAYS, K_CALL, K_EXIT, K_BAD
  } kind_e;
endpackage

// File: rtl/jr_decode.sv
module jr_decode
  import jr_pkg::*;
(
  input  logic [7:0] op,
  output cond_e      code,
  output logic       use_reg,
  output logic       narrow,
  output kind_e      kind
);
  logic [2:0] cls;

  always_comb begin
    cls     = op[2:0];
    code    = cond_e'(op[7:4]);
    use_reg = op[3];
    narrow  = (cls == CLS_NARROW);
    kind    = K_COND;
    if (cls != CLS_WIDE && cls != CLS_NARROW) begin
      kind = K_BAD;
    end else begin
      unique case (code)
        C_ALWAYS:       kind = narrow  ? K_BAD : K_ALWAYS;
        C_CALL:         kind = use_reg ? K_BAD : K_CALL;
        C_EXIT:         kind = narrow  ? K_BAD : K_EXIT;
        C_RSV0, C_RSV1: kind = K_BAD;
        default:        kind = K_COND;
      endcase
    end
  end
endmodule

// File: rtl/jr_operand.sv
module jr_operand #(
  parameter int XLEN = 64,
  parameter int HALF = 32,
  parameter int IMMW = 32
) (
  input  logic            narrow,
  input  logic            use_reg,
  input  logic [XLEN-1:0] dst,
  input  logic [XLEN-1:0] src,
  input  logic [IMMW-1:0] imm,
  output logic [XLEN-1:0] ua,
  output logic [XLEN-1:0] ub,
  output logic [XLEN-1:0] sa,
  output logic [XLEN-1:0] sb
);
  localparam int IPAD = XLEN - IMMW;
  localparam int HPAD = XLEN - HALF;

  logic [XLEN-1:0] imm_x;
  logic [XLEN-1:0] rhs;

  generate
    if (IPAD > 0) begin : g_ipad
      assign imm_x = {{IPAD{imm[IMMW-1]}}, imm};
    end else begin : g_inopad
      assign imm_x = imm[XLEN-1:0];
    end
  endgenerate

  assign rhs = use_reg ? src : imm_x;

  always_comb begin
    if (narrow) begin
      ua = {{HPAD{1'b0}}, dst[HALF-1:0]};
      ub = {{HPAD{1'b0}}, rhs[HALF-1:0]};
      sa = {{HPAD{dst[HALF-1]}}, dst[HALF-1:0]};
      sb = {{HPAD{rhs[HALF-1]}}, rhs[HALF-1:0]};
    end else begin
      ua = dst;
      ub = rhs;
      sa = dst;
      sb = rhs;
    end
  end
endmodule

// File: rtl/jr_cond.sv
module jr_cond
  import jr_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  cond_e           code,
  input  logic [XLEN-1:0] ua,
  input  logic [XLEN-1:0] ub,
  input  logic [XLEN-1:0] sa,
  input  logic [XLEN-1:0] sb,
  output logic            hit
);
  logic lt_u, lt_s, eq;

  assign eq   = (ua == ub);
  assign lt_u = (ua < ub);
  assign lt_s = ($signed(sa) < $signed(sb));

  always_comb begin
    unique case (code)
      C_EQ:    hit = eq;
      C_NE:    hit = !eq;
      C_UGT:   hit = !lt_u && !eq;
      C_UGE:   hit = !lt_u;
      C_ULT:   hit = lt_u;
      C_ULE:   hit = lt_u || eq;
      C_SGT:   hit = !lt_s && !eq;
      C_SGE:   hit = !lt_s;
      C_SLT:   hit = lt_s;
      C_SLE:   hit = lt_s || eq;
      C_SET:   hit = |(ua & ub);
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/jump_resolver.sv
module jump_resolver
  import jr_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int HALF = 32,
  parameter int IMMW = 32,
  parameter int OFFW = 16,
  parameter int PCW  = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [7:0]      opcode,
  input  logic [OFFW-1:0] offset,
  input  logic [IMMW-1:0] imm,
  input  logic [XLEN-1:0] dst_val,
  input  logic [XLEN-1:0] src_val,
  input  logic [PCW-1:0]  pc,
  output logic            out_valid,
  output logic [PCW-1:0]  next_pc,
  output logic            taken,
  output logic            call_stb,
  output logic [IMMW-1:0] call_fn,
  output logic            halt_stb,
  output logic            illegal
);
  localparam int OPAD = PCW - OFFW;

  // reset release synchroniser
  logic [1:0] rst_pipe;
  logic       run_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign run_n = rst_pipe[1];

  cond_e           code;
  kind_e           kind;
  logic            use_reg, narrow, hit;
  logic [XLEN-1:0] ua, ub, sa, sb;

  jr_decode u_dec (
    .op(opcode), .code(code), .use_reg(use_reg), .narrow(narrow), .kind(kind)
  );

  jr_operand #(.XLEN(XLEN), .HALF(HALF), .IMMW(IMMW)) u_opr (
    .narrow(narrow), .use_reg(use_reg), .dst(dst_val), .src(src_val),
    .imm(imm), .ua(ua), .ub(ub), .sa(sa), .sb(sb)
  );

  jr_cond #(.XLEN(XLEN)) u_cnd (
    .code(code), .ua(ua), .ub(ub), .sa(sa), .sb(sb), .hit(hit)
  );

  // next-state
  logic [PCW-1:0] step_pc, tgt_pc, npc_d;
  logic           tk_d, cl_d, hl_d, bad_d;

  assign step_pc = pc + PCW'(1);
  assign tgt_pc  = step_pc + {{OPAD{offset[OFFW-1]}}, offset};

  always_comb begin
    tk_d  = 1'b0;
    cl_d  = 1'b0;
    hl_d  = 1'b0;
    bad_d = 1'b0;
    unique case (kind)
      K_COND:   tk_d  = hit;
      K_ALWAYS: tk_d  = 1'b1;
      K_CALL:   cl_d  = 1'b1;
      K_EXIT:   hl_d  = 1'b1;
      default:  bad_d = 1'b1;
    endcase
    npc_d = tk_d ? tgt_pc : step_pc;
  end

  // registers
  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      call_stb  <= 1'b0;
      halt_stb  <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      taken     <= in_valid & tk_d;
      call_stb  <= in_valid & cl_d;
      halt_stb  <= in_valid & hl_d;
      illegal   <= in_valid & bad_d;
    end
  end

  always_ff @(posedge clk or negedge run_n) begin
    if (!run_n) begin
      next_pc <= '0;
      call_fn <= '0;
    end else begin
      if (in_valid)        next_pc <= npc_d;
      if (in_valid & cl_d) call_fn <= imm;
    end
  end
endmodule

// File: rtl/jump_resolver_chk.sv
module jump_resolver_chk #(
  parameter int IMMW = 32,
  parameter int OFFW = 16,
  parameter int PCW  = 32
) (
  input logic            clk,
  input logic            run_n,
  input logic            in_valid,
  input logic [7:0]      opcode,
  input logic [OFFW-1:0] offset,
  input logic [IMMW-1:0] imm,
  input logic [PCW-1:0]  pc,
  input logic            out_valid,
  input logic [PCW-1:0]  next_pc,
  input logic            taken,
  input logic            call_stb,
  input logic [IMMW-1:0] call_fn,
  input logic            halt_stb,
  input logic            illegal
);
  logic [PCW-1:0] off_x;
  assign off_x = {{(PCW-OFFW){offset[OFFW-1]}}, offset};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!run_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!run_n)
    !in_valid |=> !out_valid && $stable(next_pc)); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!run_n)
    !out_valid |-> !taken && !call_stb && !halt_stb && !illegal); // R2
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!run_n)
    $onehot0({taken, call_stb, halt_stb, illegal})); // R11
  AST_TARGET: assert property (@(posedge clk) disable iff (!run_n)
    in_valid |=> taken ? (next_pc == $past(pc) + PCW'(1) + $past(off_x))
                       : (next_pc == $past(pc) + PCW'(1))); // R6
  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!run_n)
    in_valid && opcode == 8'h05 |=> taken); // R7
  AST_CALL_NUMBER: assert property (@(posedge clk) disable iff (!run_n)
    in_valid && opcode == 8'h85 |=> call_stb && call_fn == $past(imm)); // R8
  AST_EXIT_HALTS: assert property (@(posedge clk) disable iff (!run_n)
    in_valid && opcode == 8'h95 |=> halt_stb); // R9
  AST_REG_CALL_BAD: assert property (@(posedge clk) disable iff (!run_n)
    in_valid && opcode == 8'h8d |=> illegal); // R10
endmodule

bind jump_resolver jump_resolver_chk #(.IMMW(IMMW), .OFFW(OFFW), .PCW(PCW)) u_chk (
  .clk(clk), .run_n(run_n), .in_valid(in_valid), .opcode(opcode),
  .offset(offset), .imm(imm), .pc(pc), .out_valid(out_valid),
  .next_pc(next_pc), .taken(taken), .call_stb(call_stb), .call_fn(call_fn),
  .halt_stb(halt_stb), .illegal(illegal)
);

// File: tb/sim_jump_resolver.sv
module sim_jump_resolver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  opcode = '0;
  logic [15:0] offset = '0;
  logic [31:0] imm = '0;
  logic [63:0] dst_val = '0, src_val = '0;
  logic [31:0] pc = '0;
  logic        out_valid, taken, call_stb, halt_stb, illegal;
  logic [31:0] next_pc, call_fn;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  jump_resolver u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .offset(offset), .imm(imm), .dst_val(dst_val), .src_val(src_val),
    .pc(pc), .out_valid(out_valid), .next_pc(next_pc), .taken(taken),
    .call_stb(call_stb), .call_fn(call_fn), .halt_stb(halt_stb),
    .illegal(illegal)
  );

  typedef struct {
    logic        v;
    logic [31:0] npc;
    logic        tk, cl, hl, bad;
    logic [31:0] fn;
    string       tag;
  } exp_t;

  exp_t        pend[$];
  logic [31:0] hold_npc = '0;

  // behavioural reference
  function automatic exp_t model(input logic [7:0] op, input logic [15:0] off,
                                 input logic [31:0] im, input logic [63:0] d,
                                 input logic [63:0] s, input logic [31:0] p,
                                 input string tag);
    exp_t e;
    int cls, code;
    logic [63:0] b;
    longint unsigned ua, ub;
    longint sa, sb;
    logic hit;
    cls  = int'(op[2:0]);
    code = int'(op[7:4]);
    b    = op[3] ? s : {{32{im[31]}}, im};
    if (cls == 6) begin
      ua = longint'(d[31:0]);  ub = longint'(b[31:0]);
      sa = longint'(int'(d[31:0])); sb = longint'(int'(b[31:0]));
    end else begin
      ua = d; ub = b; sa = d; sb = b;
    end
    case (code)
      1: hit = ua == ub;   5: hit = ua != ub;
      2: hit = ua > ub;    3: hit = ua >= ub;
      10: hit = ua < ub;   11: hit = ua <= ub;
      6: hit = sa > sb;    7: hit = sa >= sb;
      12: hit = sa < sb;   13: hit = sa <= sb;
      4: hit = (ua & ub) != 0;
      default: hit = 1'b0;
    endcase
    e.v = 1'b1; e.tag = tag; e.fn = im;
    e.bad = !(cls == 5 || cls == 6) || code >= 14 || (code == 8 && op[3])
            || (cls == 6 && (code == 0 || code == 9));
    e.cl  = !e.bad && code == 8;
    e.hl  = !e.bad && code == 9;
    e.tk  = !e.bad && (code == 0 || hit);
    e.npc = e.tk ? p + 32'd1 + {{16{off[15]}}, off} : p + 32'd1;
    return e;
  endfunction

  task automatic compare(input exp_t e);
    logic ok;
    if (!e.v) begin
      ok = !out_valid && !taken && !call_stb && !halt_stb && !illegal
           && next_pc == hold_npc;
    end else begin
      ok = out_valid && taken == e.tk && call_stb == e.cl && halt_stb == e.hl
           && illegal == e.bad && next_pc == e.npc && (!e.cl || call_fn == e.fn);
      hold_npc = e.npc;
    end
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: got v=%0b npc=%h tk=%0b cl=%0b fn=%h hl=%0b bad=%0b exp v=%0b npc=%h tk=%0b cl=%0b fn=%h hl=%0b bad=%0b",
               e.tag, out_valid, next_pc, taken, call_stb, call_fn, halt_stb, illegal,
               e.v, e.v ? e.npc : hold_npc, e.tk, e.cl, e.fn, e.hl, e.bad);
    end
  endtask

  // one clock: check what the previous edge produced, then drive the next input
  task automatic cyc(input logic v, input logic [7:0] op, input logic [15:0] off,
                     input logic [31:0] im, input logic [63:0] d, input logic [63:0] s,
                     input logic [31:0] p, input string tag);
    exp_t e;
    @(negedge clk);
    if (pend.size() > 0) compare(pend.pop_front());
    in_valid = v; opcode = op; offset = off; imm = im;
    dst_val = d; src_val = s; pc = p;
    if (v) e = model(op, off, im, d, s, p, tag);
    else begin e.v = 1'b0; e.tag = "R2 idle"; end
    pend.push_back(e);
  endtask

  task automatic idle();
    cyc(1'b0, 8'h00, 16'h0, 32'h0, 64'h0, 64'h0, 32'h0, "R2");
  endtask

  localparam logic [63:0] ALL1 = 64'hFFFF_FFFF_FFFF_FFFF;

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: got hang exp finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    // R1 reset state
    repeat (2) @(negedge clk);
    checks++;
    if (out_valid || taken || call_stb || halt_stb || illegal || next_pc != 0) begin
      failures++;
      $display("FAIL R1: got v=%0b npc=%h exp all zero", out_valid, next_pc);
    end
    rst_n = 1'b1;
    repeat (4) idle();

    // R4 64-bit register compares: -1 vs 1 separates signed from unsigned
    for (int c = 1; c <= 13; c++) begin
      if (c == 8 || c == 9) continue;
      cyc(1'b1, {4'(c), 4'hd}, 16'h0010, 32'h0, ALL1, 64'h1, 32'h100, "R4 mixed");
      cyc(1'b1, {4'(c), 4'hd}, 16'h0010, 32'h0, 64'h5, 64'h5, 32'h200, "R4 equal");
      cyc(1'b1, {4'(c), 4'hd}, 16'hfff0, 32'h0, 64'h3, 64'h9, 32'h300, "R4 less");
    end
    // R3 immediate sign extension in the 64-bit class
    cyc(1'b1, 8'h15, 16'h0004, 32'hFFFF_FFFF, ALL1, 64'h0, 32'h40, "R3 imm sext eq");
    cyc(1'b1, 8'h25, 16'h0004, 32'h8000_0000, 64'h1, 64'h0, 32'h40, "R3 imm ugt");
    cyc(1'b1, 8'h65, 16'h0004, 32'h8000_0000, 64'h1, 64'h0, 32'h40, "R3 imm sgt");
    cyc(1'b1, 8'h45, 16'h0002, 32'h0000_0100, 64'h0000_0001_0000_0100, 64'h0, 32'h8, "R4 set hit");
    cyc(1'b1, 8'h4d, 16'h0002, 32'h0, 64'hF0, 64'h0F, 32'h8, "R4 set miss");
    idle();
    // R5 32-bit class: upper halves ignored, sign from bit 31
    cyc(1'b1, 8'h1e, 16'h0007, 32'h0, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 32'h10, "R5 eq low");
    cyc(1'b1, 8'h5e, 16'h0007, 32'h0, 64'hAAAA_0000_1234_5678, 64'h5555_0000_1234_5678, 32'h10, "R5 ne low");
    cyc(1'b1, 8'h6e, 16'h0007, 32'h0, 64'h0000_0000_8000_0000, 64'h1, 32'h10, "R5 sgt bit31");
    cyc(1'b1, 8'h2e, 16'h0007, 32'h0, 64'h0000_0000_8000_0000, 64'h1, 32'h10, "R5 ugt bit31");
    cyc(1'b1, 8'hc6, 16'h0007, 32'hFFFF_FFFF, 64'hFFFF_FFFF_0000_0000, 64'h0, 32'h10, "R5 slt imm");
    cyc(1'b1, 8'hbe, 16'h0007, 32'h0, 64'h1_0000_0003, 64'h0_0000_0003, 32'h10, "R5 ule");
    // R6 / R7 offset wrap and unconditional jump
    cyc(1'b1, 8'h05, 16'hfffe, 32'h0, 64'h0, 64'h0, 32'h0, "R7 R6 wrap low");
    cyc(1'b1, 8'h05, 16'h7fff, 32'h0, 64'h0, 64'h0, 32'hFFFF_FFF0, "R7 R6 wrap high");
    cyc(1'b1, 8'h55, 16'h8000, 32'h0, 64'h0, 64'h0, 32'h1234, "R6 not taken");
    idle(); idle();
    // R8 call, R9 exit
    cyc(1'b1, 8'h85, 16'h0009, 32'h0000_00A7, 64'h0, 64'h0, 32'h50, "R8 call wide");
    cyc(1'b1, 8'h86, 16'h0009, 32'hDEAD_0001, 64'h0, 64'h0, 32'h60, "R8 call narrow");
    cyc(1'b1, 8'h95, 16'h0009, 32'h0, 64'h0, 64'h0, 32'h70, "R9 exit");
    cyc(1'b1, 8'h9d, 16'h0009, 32'h0, 64'h0, 64'h0, 32'h71, "R9 exit reg");
    // R10 illegal encodings
    cyc(1'b1, 8'h8d, 16'h0009, 32'h5, 64'h0, 64'h0, 32'h80, "R10 reg call");
    cyc(1'b1, 8'h06, 16'h0009, 32'h0, 64'h0, 64'h0, 32'h81, "R10 narrow always");
    cyc(1'b1, 8'h96, 16'h0009, 32'h0, 64'h0, 64'h0, 32'h82, "R10 narrow exit");
    cyc(1'b1, 8'he5, 16'h0009, 32'h0, 64'h0, 64'h0, 32'h83, "R10 code e");
    cyc(1'b1, 8'hfe, 16'h0009, 32'h0, 64'h0, 64'h0, 32'h84, "R10 code f");
    cyc(1'b1, 8'h15, 16'h0009, 32'h0, 64'h0, 64'h0, 32'h85, "R11 after illegal");
    cyc(1'b1, 8'h17, 16'h0009, 32'h0, 64'h0, 64'h0, 32'h86, "R10 alu class");
    cyc(1'b1, 8'h1c, 16'h0009, 32'h0, 64'h0, 64'h0, 32'h87, "R10 class 4");
    idle(); idle();
    // R11 mixed stream
    for (int i = 0; i < 40; i++) begin
      logic [7:0] op;
      op = {4'(i % 16), 1'(i % 3 == 0), (i % 2 == 0) ? 3'd5 : 3'd6};
      if (i % 7 == 3) idle();
      cyc(1'b1, op, 16'(i * 97), 32'(i * 12345), 64'(i) * 64'h0123_4567_89AB, 64'(40 - i) << 30,
          32'(i * 4099), "R11 stream");
    end
    idle(); idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule